// File: doc/BRIEF.md
# Compare and Condition Evaluator

This block subtracts a source operand from a destination operand, keeps the status flags of that difference in a small register, and evaluates any of sixteen branch-style conditions against the stored flags. Neither operand is modified. Only the flags are kept from a compare. A compare is requested by raising a strobe for one clock. The flags appear on the next cycle and stay there until the next compare or reset.

The condition result is produced combinationally from the stored flags and the current 4-bit condition select. The block offers it in three forms: a single condition bit, a byte that reads 01h or 00h, and a conditional-move result. The move result passes the move source when the condition holds and the old destination value otherwise. Any number of conditions can be tested against one compare by changing the select.

All pins are plain control and data pins. A compare completes in one cycle and the condition outputs are always valid, so there is no valid/ready handshake and no back-pressure. A caller that holds the strobe high gets a new compare on every cycle.

Top module: `flag_cond_unit`

## Requirements
- R1: While reset is low, and after it is released, the stored flags read all zero until the first compare.
- R2: When `cmp_strobe` is high at a rising clock edge, the flags computed from `op_dst - op_src` are visible on `flags` from the next cycle. ZF is 1 exactly when the operands are equal.
- R3: When `cmp_strobe` is low, `flags` keeps its value whatever the operands do.
- R4: The flag bit positions are: bit 0 CF, the borrow out of the unsigned subtraction; bit 1 PF; bit 2 AF; bit 3 ZF, set when the 16-bit difference is zero; bit 4 SF, the difference's top bit; bit 5 OF.
- R5: OF is set when the operand signs differ and the sign of the difference differs from the destination's sign. PF is 1 when the low byte of the difference has an even number of ones. AF is the borrow out of bit 3.
- R6: The single-flag condition codes are: 0 OF=1, 1 OF=0, 2 CF=1, 3 CF=0, 4 ZF=1, 5 ZF=0, 8 SF=1, 9 SF=0, 10 PF=1, 11 PF=0.
- R7: The unsigned compound codes are: 6 when CF or ZF is set (destination at or below source), and 7 when both are clear (destination above source).
- R8: The signed codes are: 12 when SF xor OF, 13 when its inverse holds, 14 when (SF xor OF) or ZF, and 15 when its inverse holds. These mean less, greater-or-equal, less-or-equal and greater.
- R9: `cond_true` follows `cond_sel` in the same cycle and uses only the stored flags, with no new compare needed.
- R10: `set_byte` is 8'h01 when the condition holds and 8'h00 otherwise.
- R11: `mov_result` equals `mov_src` when the condition holds and `mov_dst` otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_strobe | input | 1 | Load the flags of op_dst - op_src |
| op_dst | input | 16 | Destination (minuend) operand |
| op_src | input | 16 | Source (subtrahend) operand |
| cond_sel | input | 4 | Condition code 0..15 |
| mov_src | input | 16 | Value moved when the condition holds |
| mov_dst | input | 16 | Value kept when the condition fails |
| flags | output | 6 | Stored flags {OF,SF,ZF,AF,PF,CF} |
| cond_true | output | 1 | Selected condition holds |
| set_byte | output | 8 | 01h if condition holds, else 00h |
| mov_result | output | 16 | Conditional-move result |

## Verification
The hardest case to reach is signed overflow together with the signed conditions it reverses. A plain less-than test cannot tell SF xor OF apart from SF unless the subtraction wraps. The sweep therefore pairs operands at the sign boundary (7FFFh, 8000h, 8001h, FFFFh) with each other and with small values, so every signed code is checked with OF both set and clear. After each compare, the bench drives unrelated operands with the strobe low and walks all sixteen selects. This checks that the conditions read only the stored flags.

// File: rtl/flag_cond_pkg.sv
package flag_cond_pkg;
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  localparam int FLAG_BITS = $bits(flags_t);

  typedef enum logic [2:0] {
    PAIR_OVF   = 3'd0,
    PAIR_CARRY = 3'd1,
    PAIR_ZERO  = 3'd2,
    PAIR_BELEQ = 3'd3,
    PAIR_SIGN  = 3'd4,
    PAIR_PAR   = 3'd5,
    PAIR_LESS  = 3'd6,
    PAIR_LESEQ = 3'd7
  } cond_pair_e;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flag_cond_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int PAR_BITS = 8,
  parameter int NIB_BITS = 4
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  output flags_t           flags_next
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]    wide_diff;
  logic [NIB_BITS:0] nib_diff;
  logic [WIDTH-1:0]  diff;

  always_comb begin
    wide_diff = {1'b0, minuend} - {1'b0, subtrahend};
    nib_diff  = {1'b0, minuend[NIB_BITS-1:0]} - {1'b0, subtrahend[NIB_BITS-1:0]};
    diff      = wide_diff[WIDTH-1:0];

    flags_next.cf = wide_diff[WIDTH];
    flags_next.zf = (diff == '0);
    flags_next.sf = diff[MSB];
    flags_next.of = (minuend[MSB] ^ subtrahend[MSB]) & (diff[MSB] ^ minuend[MSB]);
    flags_next.pf = ~^diff[PAR_BITS-1:0];
    flags_next.af = nib_diff[NIB_BITS];
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_cond_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  // An equal compare cannot borrow, overflow or be negative.
  assert_zero_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q.zf |-> (!q.cf && !q.of && !q.sf));
endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import flag_cond_pkg::*;
#(
  parameter int SEL_BITS = 4
) (
  input  flags_t              f,
  input  logic [SEL_BITS-1:0] sel,
  output logic                hit
);
  cond_pair_e pair;
  logic       base;

  always_comb begin
    pair = cond_pair_e'(sel[SEL_BITS-1:1]);
    unique case (pair)
      PAIR_OVF:   base = f.of;
      PAIR_CARRY: base = f.cf;
      PAIR_ZERO:  base = f.zf;
      PAIR_BELEQ: base = f.cf | f.zf;
      PAIR_SIGN:  base = f.sf;
      PAIR_PAR:   base = f.pf;
      PAIR_LESS:  base = f.sf ^ f.of;
      PAIR_LESEQ: base = (f.sf ^ f.of) | f.zf;
      default:    base = 1'b0;
    endcase
    hit = base ^ sel[0];
  end
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flag_cond_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int SEL_BITS  = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_strobe,
  input  logic [WIDTH-1:0]     op_dst,
  input  logic [WIDTH-1:0]     op_src,
  input  logic [SEL_BITS-1:0]  cond_sel,
  input  logic [WIDTH-1:0]     mov_src,
  input  logic [WIDTH-1:0]     mov_dst,
  output logic [FLAG_BITS-1:0] flags,
  output logic                 cond_true,
  output logic [BYTE_BITS-1:0] set_byte,
  output logic [WIDTH-1:0]     mov_result
);
  flags_t next_f;
  flags_t held_f;

  flag_calc #(.WIDTH(WIDTH), .PAR_BITS(8), .NIB_BITS(4)) u_calc (
    .minuend    (op_dst),
    .subtrahend (op_src),
    .flags_next (next_f)
  );

  flag_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmp_strobe),
    .d     (next_f),
    .q     (held_f)
  );

  cond_decode #(.SEL_BITS(SEL_BITS)) u_dec (
    .f   (held_f),
    .sel (cond_sel),
    .hit (cond_true)
  );

  assign flags      = held_f;
  assign set_byte   = {{(BYTE_BITS-1){1'b0}}, cond_true};
  assign mov_result = cond_true ? mov_src : mov_dst;

  assert_zf_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |=> (flags[3] == ($past(op_dst) == $past(op_src))));

  assert_cf_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |=> (flags[0] == ($past(op_dst) < $past(op_src))));

  assert_byte_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_byte[BYTE_BITS-1:1] == '0);

  assert_move_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_byte[0] |-> (mov_result == mov_src));

  assert_move_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !set_byte[0] |-> (mov_result == mov_dst));

  assert_equal_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd4 && cond_true) |-> flags[3]);
endmodule

// File: tb/flag_cond_unit_bench.sv
module flag_cond_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_strobe = 1'b0;
  logic [15:0] op_dst = '0, op_src = '0, mov_src = '0, mov_dst = '0;
  logic [3:0]  cond_sel = '0;
  logic [5:0]  flags;
  logic        cond_true;
  logic [7:0]  set_byte;
  logic [15:0] mov_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flag_cond_unit u_flag_cond_unit (
    .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe),
    .op_dst(op_dst), .op_src(op_src), .cond_sel(cond_sel),
    .mov_src(mov_src), .mov_dst(mov_dst), .flags(flags),
    .cond_true(cond_true), .set_byte(set_byte), .mov_result(mov_result)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_flags(input logic [15:0] d, input logic [15:0] s);
    logic [15:0] r;
    int sd;
    logic of_b, sf_b, zf_b, af_b, pf_b, cf_b;
    r    = d - s;
    sd   = $signed(d) - $signed(s);
    cf_b = d < s;
    zf_b = d == s;
    sf_b = r[15];
    of_b = (sd > 32767) || (sd < -32768);
    af_b = d[3:0] < s[3:0];
    pf_b = ($countones(r[7:0]) % 2) == 0;
    return {of_b, sf_b, zf_b, af_b, pf_b, cf_b};
  endfunction

  function automatic bit exp_cond(input logic [15:0] d, input logic [15:0] s,
                                  input int sel);
    logic [5:0] f;
    bit b;
    f = exp_flags(d, s);
    case (sel / 2)
      0: b = f[5];
      1: b = d < s;
      2: b = d == s;
      3: b = d <= s;
      4: b = f[4];
      5: b = f[1];
      6: b = $signed(d) < $signed(s);
      default: b = $signed(d) <= $signed(s);
    endcase
    return (sel % 2) ? !b : b;
  endfunction

  function automatic string req_of(input int sel);
    if (sel == 6 || sel == 7) return "R7";
    if (sel >= 12) return "R8";
    return "R6";
  endfunction

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_pair(input logic [15:0] d, input logic [15:0] s);
    logic [5:0] ef;
    @(negedge clk);
    op_dst = d; op_src = s; cmp_strobe = 1'b1;
    @(negedge clk);
    cmp_strobe = 1'b0;
    ef = exp_flags(d, s);
    check(flags == ef, "R2 R4 R5 flags", {26'd0, flags}, {26'd0, ef});
    for (int sel = 0; sel < 16; sel++) begin
      lfsr = step(lfsr);
      op_dst = lfsr; op_src = ~lfsr ^ 16'h0F0F;
      mov_src = lfsr ^ 16'h5A5A; mov_dst = ~lfsr;
      cond_sel = sel[3:0];
      #2;
      check(cond_true == exp_cond(d, s, sel), req_of(sel), {31'd0, cond_true},
            {31'd0, exp_cond(d, s, sel)});
      check(set_byte == (exp_cond(d, s, sel) ? 8'h01 : 8'h00), "R10 set byte",
            {24'd0, set_byte}, exp_cond(d, s, sel) ? 32'h1 : 32'h0);
      check(mov_result == (exp_cond(d, s, sel) ? mov_src : mov_dst), "R11 move",
            {16'd0, mov_result}, {16'd0, exp_cond(d, s, sel) ? mov_src : mov_dst});
      @(negedge clk);
      check(flags == ef, "R3 R9 hold", {26'd0, flags}, {26'd0, ef});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] vals [16];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h000F, 16'h0010, 16'h007F,
             16'h0080, 16'h00FF, 16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001,
             16'hABCD, 16'hDCBA, 16'hFFFE, 16'hFFFF};
    cmp_strobe = 1'b1; op_dst = 16'h1234; op_src = 16'h4321;
    repeat (3) @(negedge clk);
    check(flags == 6'd0, "R1 reset flags", {26'd0, flags}, 32'd0);
    rst_n = 1'b1; cmp_strobe = 1'b0;
    @(negedge clk);
    check(flags == 6'd0, "R1 after release", {26'd0, flags}, 32'd0);
    cond_sel = 4'd1; #1;
    check(cond_true == 1'b1, "R1 R6 NO after reset", {31'd0, cond_true}, 32'd1);
    cond_sel = 4'd0; #1;
    check(set_byte == 8'h00, "R1 R10 O after reset", {24'd0, set_byte}, 32'd0);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_pair(vals[i], vals[j]);
    for (int k = 0; k < 200; k++) begin
      logic [15:0] a;
      lfsr = step(lfsr); a = lfsr;
      lfsr = step(lfsr);
      run_pair(a, (k % 7 == 0) ? a : lfsr);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule